// File: doc/BRIEF.md
# Execute-Stage Redirect and Squash Unit

This unit produces the fetch address and the squash controls for a five-stage in-order pipeline in which branches and jumps are resolved in the execute stage. Fetch assumes that control transfers are not taken and keeps issuing sequential addresses. When the instruction in EX turns out to be a taken branch or a jump, the unit loads the resolved target into the fetch address register. On the same clock it kills the younger instructions that were fetched on the wrong path by turning them into no-ops.

A module parameter selects between two conventions. In speculative mode, both younger instructions are killed: the one in decode and the one being fetched. In delay-slot mode, the instruction right after the control transfer always completes, and only the one behind it is killed. The branch comparison and any prediction tables are outside this block. The unit only consumes the resolved outcome.

Top module: `brsq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fetch_pc` equals `RESET_PC`, and `ifid_flush` and `idex_flush` are low when no resolution is presented.
- R2: With no redirect and `id_hold` low, `fetch_pc` increases by `PC_STEP` (4) on each clock.
- R3: With no redirect and `id_hold` high, `fetch_pc` keeps its value and neither flush is asserted.
- R4: In speculative mode, a redirect asserts `ifid_flush` and `idex_flush` in the same cycle. A redirect is `ex_ctl_valid` and `ex_ctl_taken` both high, and a jump is presented with both high. `fetch_pc` equals `ex_ctl_target` after the next clock.
- R5: In delay-slot mode, `idex_flush` is never asserted, and a redirect without `id_hold` asserts only `ifid_flush`.
- R6: A redirect loads `ex_ctl_target` into `fetch_pc` even when `id_hold` is high in the same cycle.
- R7: A not-taken resolution (`ex_ctl_valid` high, `ex_ctl_taken` low) asserts no flush and leaves `fetch_pc` on its sequential or held path.
- R8: In delay-slot mode, a redirect during `id_hold` asserts no flush, so the held delay-slot instruction in IF/ID survives.
- R9: When a five-stage pipeline is driven by this unit, the instructions that reach writeback follow sequential program order with taken transfers applied. In delay-slot mode, the single instruction after each transfer also completes.
- R10: `ex_ctl_taken` and `ex_ctl_target` have no effect while `ex_ctl_valid` is low: there is no flush and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_ctl_valid | input | 1 | The EX instruction is a live branch or jump |
| ex_ctl_taken | input | 1 | Resolved outcome: taken (always 1 for jumps) |
| ex_ctl_target | input | AW | Resolved target address |
| id_hold | input | 1 | Decode stall: hold IF/ID and the fetch address |
| fetch_pc | output | AW | Address being fetched this cycle (registered) |
| ifid_flush | output | 1 | Replace the instruction entering IF/ID with a no-op |
| idex_flush | output | 1 | Replace the instruction entering ID/EX with a no-op |

## Verification
The assertions assume that `ex_ctl_valid` is raised only for a live control instruction that is actually in EX, never for one already squashed. They also assume that in delay-slot mode no control transfer sits in a delay slot. The stimulus meets both conditions because a bench pipeline model drives the EX inputs from the instruction it holds in EX. Its generated program places branches and jumps only at even word addresses, so every delay slot holds an ordinary instruction. Stalls are drawn at random, independently of branch position, so resolutions that coincide with a hold occur in both modes.

// File: rtl/brsq_pkg.sv
package brsq_pkg;

  // Squash convention selected at build time
  typedef enum logic {
    BRSQ_SPECULATE  = 1'b0,
    BRSQ_DELAY_SLOT = 1'b1
  } brsq_mode_e;

  // Per-register kill request
  typedef struct packed {
    logic ifid;
    logic idex;
  } brsq_kill_t;

endpackage

// File: rtl/brsq_resolve.sv
module brsq_resolve #(
  parameter brsq_pkg::brsq_mode_e MODE = brsq_pkg::BRSQ_SPECULATE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ex_valid,
  input  logic                ex_taken,
  input  logic                id_hold,
  output logic                redirect,
  output brsq_pkg::brsq_kill_t kill
);
  import brsq_pkg::*;

  // Only a live control instruction can steer fetch.
  assign redirect = ex_valid & ex_taken;

  generate
    if (MODE == BRSQ_SPECULATE) begin : g_spec
      // Both younger instructions are on the wrong path.
      always_comb begin
        kill.ifid = redirect;
        kill.idex = redirect;
      end

      // R6
      spec_hold_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect && id_hold) |-> (kill.ifid && kill.idex));
    end else begin : g_dslot
      // The decode-stage instruction is the delay slot and must live.
      // During a hold the slot sits in IF/ID and the stall bubbles ID/EX.
      always_comb begin
        kill.ifid = redirect & ~id_hold;
        kill.idex = 1'b0;
      end

      // R8
      dslot_hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_taken && id_hold) |-> !kill.ifid);
    end
  endgenerate

endmodule

// File: rtl/brsq_pc.sv
module brsq_pc #(
  parameter int          AW       = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect,
  input  logic          hold,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q
);
  localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_PC;
    else if (redirect) pc_q <= target;
    else if (!hold)    pc_q <= pc_q + STEP_V;
  end

  // R4
  redirect_load_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc_q == $past(target)));

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!redirect && hold) |=> $stable(pc_q));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!redirect && !hold) |=> (pc_q == $past(pc_q) + STEP_V));

endmodule

// File: rtl/brsq_ctrl.sv
module brsq_ctrl #(
  parameter int                   AW       = 32,
  parameter int                   PC_STEP  = 4,
  parameter logic [AW-1:0]        RESET_PC = '0,
  parameter brsq_pkg::brsq_mode_e MODE     = brsq_pkg::BRSQ_SPECULATE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_ctl_valid,
  input  logic          ex_ctl_taken,
  input  logic [AW-1:0] ex_ctl_target,
  input  logic          id_hold,
  output logic [AW-1:0] fetch_pc,
  output logic          ifid_flush,
  output logic          idex_flush
);
  import brsq_pkg::*;

  logic       redirect;
  brsq_kill_t kill;

  brsq_resolve #(.MODE(MODE)) u_resolve (
    .clk      (clk),
    .rst      (rst),
    .ex_valid (ex_ctl_valid),
    .ex_taken (ex_ctl_taken),
    .id_hold  (id_hold),
    .redirect (redirect),
    .kill     (kill)
  );

  brsq_pc #(.AW(AW), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .redirect (redirect),
    .hold     (id_hold),
    .target   (ex_ctl_target),
    .pc_q     (fetch_pc)
  );

  assign ifid_flush = kill.ifid;
  assign idex_flush = kill.idex;

  // R10
  flush_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (ifid_flush || idex_flush) |-> (ex_ctl_valid && ex_ctl_taken));

  // R7
  not_taken_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_ctl_valid && !ex_ctl_taken) |-> (!ifid_flush && !idex_flush));

  generate
    if (MODE == BRSQ_SPECULATE) begin : g_chk_spec
      // R4
      spec_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_ctl_valid && ex_ctl_taken) |-> (ifid_flush && idex_flush));
    end else begin : g_chk_dslot
      // R5
      dslot_no_idex_chk: assert property (@(posedge clk) disable iff (rst)
        !(idex_flush && ex_ctl_valid));
    end
  endgenerate

endmodule

// File: tb/test_brsq_ctrl.sv
`timescale 1ns/1ps
module test_brsq_ctrl;
  import brsq_pkg::*;

  localparam int          AW    = 32;
  localparam int          STEP  = 4;
  localparam logic [31:0] RSTPC = 32'h100;
  localparam int          NCYC  = 3000;
  localparam int          NREF  = 4096;

  typedef struct { bit v; logic [31:0] pc; } slot_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        v   [2];
  logic        tk  [2];
  logic        hd  [2];
  logic [31:0] tg  [2];
  logic [31:0] fpc [2];
  logic        fif [2];
  logic        fid [2];

  brsq_ctrl #(.AW(AW), .PC_STEP(STEP), .RESET_PC(RSTPC), .MODE(BRSQ_SPECULATE)) i_brsq_ctrl (
    .clk(clk), .rst(rst), .ex_ctl_valid(v[0]), .ex_ctl_taken(tk[0]),
    .ex_ctl_target(tg[0]), .id_hold(hd[0]), .fetch_pc(fpc[0]),
    .ifid_flush(fif[0]), .idex_flush(fid[0]));

  brsq_ctrl #(.AW(AW), .PC_STEP(STEP), .RESET_PC(RSTPC), .MODE(BRSQ_DELAY_SLOT)) i_brsq_ctrl_dslot (
    .clk(clk), .rst(rst), .ex_ctl_valid(v[1]), .ex_ctl_taken(tk[1]),
    .ex_ctl_target(tg[1]), .id_hold(hd[1]), .fetch_pc(fpc[1]),
    .ifid_flush(fif[1]), .idex_flush(fid[1]));

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Program: control instructions only at even word addresses
  function automatic logic [31:0] hsh(input logic [31:0] a);
    logic [31:0] h;
    h = (a >> 2) * 32'h9E3779B1;
    return h ^ (h >> 15);
  endfunction

  function automatic int kind(input logic [31:0] a); // 0 plain, 1 branch, 2 jump
    logic [31:0] h;
    if (a[2]) return 0;
    h = hsh(a);
    if (h[3:0] < 4'd3) return 1;
    if (h[3:0] == 4'd3) return 2;
    return 0;
  endfunction

  function automatic bit taken(input logic [31:0] a);
    return (kind(a) == 2) || (kind(a) == 1 && hsh(a)[6]);
  endfunction

  function automatic logic [31:0] target(input logic [31:0] a);
    return {20'd0, hsh(a)[17:8], 2'b00} + RSTPC;
  endfunction

  logic [31:0] refpc [2][NREF];
  slot_t s_ifid[2], s_idex[2], s_exmem[2];
  logic [31:0] exp_pc[2];
  int nret[2];
  int n_hold_red[2], n_jump[2], n_nt[2];

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // Sequential reference traces
    for (int m = 0; m < 2; m++) begin
      logic [31:0] p;
      int i;
      p = RSTPC; i = 0;
      while (i < NREF) begin
        refpc[m][i] = p; i++;
        if (kind(p) != 0 && taken(p)) begin
          if (m == 1 && i < NREF) begin refpc[m][i] = p + 4; i++; end
          p = target(p);
        end else p = p + 4;
      end
      s_ifid[m] = '{1'b0, 32'd0}; s_idex[m] = '{1'b0, 32'd0}; s_exmem[m] = '{1'b0, 32'd0};
      v[m] = 0; tk[m] = 0; hd[m] = 0; tg[m] = 0;
      exp_pc[m] = RSTPC; nret[m] = 0;
      n_hold_red[m] = 0; n_jump[m] = 0; n_nt[m] = 0;
    end

    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // R1 reset state
      chk(fpc[m] == RSTPC, "R1", "pc in reset", fpc[m], RSTPC);
      chk(!fif[m] && !fid[m], "R1", "flush in reset", {fif[m], fid[m]}, 0);
    end
    // R10 taken and target without valid during reset: no effect afterwards
    tk[0] = 1; tk[1] = 1; tg[0] = 32'hdead0; tg[1] = 32'hdead0;
    #1;
    for (int m = 0; m < 2; m++)
      chk(!fif[m] && !fid[m], "R10", "flush with valid low", {fif[m], fid[m]}, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < NCYC; c++) begin
      for (int m = 0; m < 2; m++) begin
        hd[m] = ($urandom % 5) == 0;
        v[m]  = s_idex[m].v && kind(s_idex[m].pc) != 0;
        tk[m] = v[m] ? taken(s_idex[m].pc) : (($urandom % 2) == 0);
        tg[m] = v[m] ? target(s_idex[m].pc) : {$urandom, 2'b00};
      end
      #1;
      for (int m = 0; m < 2; m++) begin
        bit red, e_if, e_id;
        string rq;
        red  = v[m] && tk[m];
        e_if = (m == 0) ? red : (red && !hd[m]);
        e_id = (m == 0) ? red : 1'b0;
        if (red && hd[m]) begin rq = (m == 0) ? "R6" : "R8"; n_hold_red[m]++; end
        else if (red) begin
          rq = (m == 0) ? "R4" : "R5";
          if (kind(s_idex[m].pc) == 2) n_jump[m]++;
        end
        else if (v[m]) begin rq = "R7"; n_nt[m]++; end
        else rq = hd[m] ? "R3" : "R10";
        chk(fif[m] == e_if, rq, "ifid_flush", fif[m], e_if);
        chk(fid[m] == e_id, rq, "idex_flush", fid[m], e_id);
        chk(fpc[m] == exp_pc[m], hd[m] ? "R3" : "R2", "fetch_pc", fpc[m], exp_pc[m]);
        // next expected pc
        if (red) exp_pc[m] = tg[m];
        else if (!hd[m]) exp_pc[m] = exp_pc[m] + STEP;
        // pipeline model: retirement into writeback
        if (s_exmem[m].v) begin
          if (nret[m] < NREF)
            chk(s_exmem[m].pc == refpc[m][nret[m]], "R9", "retired pc",
                s_exmem[m].pc, refpc[m][nret[m]]);
          nret[m]++;
        end
        s_exmem[m] = s_idex[m];
        if (fid[m] || hd[m]) s_idex[m] = '{1'b0, 32'd0};
        else s_idex[m] = s_ifid[m];
        if (fif[m]) s_ifid[m] = '{1'b0, 32'd0};
        else if (!hd[m]) s_ifid[m] = '{1'b1, fpc[m]};
      end
      @(negedge clk);
    end

    for (int m = 0; m < 2; m++) begin
      chk(nret[m] > 500, "R9", "retired count", nret[m], 500);
      chk(n_hold_red[m] > 0, (m == 0) ? "R6" : "R8", "redirect during hold seen", n_hold_red[m], 1);
      chk(n_jump[m] > 0, "R4", "jump seen", n_jump[m], 1);
      chk(n_nt[m] > 0, "R7", "not-taken seen", n_nt[m], 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule